// File: doc/BRIEF.md
# Module Soft-Reset and Clock-Gate Control Register

This block holds the reset and clock-enable control for one downstream module. It sits on a simple 32-bit register bus and has three write addresses. A write to the base offset replaces the two control bits. A write to the set offset turns on only the bits that are 1 in the write data. A write to the clear offset turns off only those bits. Reads at any of the three offsets return the current register.

The top bit is the soft-reset bit. The bit below it is the clock-gate bit. A change written to soft reset does not appear at once. It moves through a settling pipeline that is `SETTLE` cycles deep, and during that time read-back still shows the old value. Once soft reset has settled to 1, hardware sets the clock-gate bit and keeps it set. Software can therefore poll the clock-gate bit to learn that a reset has taken hold.

The usual enable sequence has two steps: clear soft reset and poll until it reads 0, then clear the clock gate. A full reset goes the other way: set soft reset, poll until the gate reads 1, clear soft reset, then clear the gate. The `ALLOW_RESET` parameter set to 0 builds an enable-only variant, in which software can never set soft reset.

Top module: `modrst_ctrl`

## Requirements
- R1: After power-on reset the soft-reset bit (bit 31) and the clock-gate bit (bit 30) both read 1, `mod_rst` is 1 and `mod_clk_en` is 0.
- R2: A write to offset 0x4 sets only the bits that are 1 in the write data. A write to offset 0x8 clears only the bits that are 1 in the write data. All other control bits keep their value.
- R3: A write to offset 0x0 loads bits 31 and 30 from the write data. Bits 29:0 of the write data are ignored, and bits 29:0 always read 0.
- R4: A value written to soft reset shows on read-back and on `mod_rst` exactly `SETTLE` (default 3) clock edges after the write edge. Before that, the old value is shown.
- R5: Once the settled soft-reset bit is 1, the clock-gate bit reads 1 from the next edge on. A software clear of the clock gate has no effect while settled soft reset is 1.
- R6: `mod_rst` equals the settled soft-reset bit, and `mod_clk_en` is the inverse of the clock-gate bit.
- R7: With `ALLOW_RESET` = 0, any write that would change soft reset from 0 to 1 leaves it at 0. Clearing soft reset and all clock-gate writes still work.
- R8: A write to an offset other than 0x0, 0x4 or 0x8 changes nothing, and a read at such an offset returns 0.
- R9: Reads at offsets 0x0, 0x4 and 0x8 return the same value.
- R10: Soft-reset writes on back-to-back cycles reach read-back in the order written. A one-cycle set followed by a clear gives a one-cycle pulse on `mod_rst`, and the gate stays set after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| mod_rst | output | 1 | Reset to the controlled module, active high |
| mod_clk_en | output | 1 | Clock enable to the controlled module |

## Verification
Every result has a fixed due cycle:
- Gate writes show on the edge they are written, so they can be read back straight after that edge.
- Soft-reset changes reach read-back and `mod_rst` `SETTLE` edges after the write edge.
- The hardware gate set follows one edge after that.
- Read data is combinational on the address.

The bench reference model advances on the same edges. It is compared with both instances, full and enable-only, half a cycle after each edge. The directed checks sample in the cycle just before and just after each due edge, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/modrst_pkg.sv
package modrst_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_BASE = 2'd1,
    WK_SET  = 2'd2,
    WK_CLR  = 2'd3
  } wr_kind_e;

  localparam int unsigned OFS_BASE = 0;
  localparam int unsigned OFS_SET  = 4;
  localparam int unsigned OFS_CLR  = 8;
endpackage

// File: rtl/modrst_rst_sync.sv
module modrst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = 1'b1;
    end else begin : g_rest
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/modrst_decode.sv
module modrst_decode
  import modrst_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_kind_e          wr_kind,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(OFS_BASE);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  logic hit_base, hit_set, hit_clr;

  always_comb begin
    hit_base = (bus_addr == A_BASE);
    hit_set  = (bus_addr == A_SET);
    hit_clr  = (bus_addr == A_CLR);
    rd_hit   = hit_base | hit_set | hit_clr;
    wr_kind  = WK_NONE;
    if (bus_wr) begin
      if (hit_base)     wr_kind = WK_BASE;
      else if (hit_set) wr_kind = WK_SET;
      else if (hit_clr) wr_kind = WK_CLR;
    end
  end
endmodule

// File: rtl/modrst_settle.sv
module modrst_settle #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_pipe
    if (g == 0) begin : g_head
      assign stage_d[g] = d;
    end else begin : g_tail
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/modrst_bits.sv
module modrst_bits
  import modrst_pkg::*;
#(
  parameter bit ALLOW_RESET = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  wr_kind_e wr_kind,
  input  logic     wr_srst,
  input  logic     wr_gate,
  input  logic     settled,
  output logic     req_q,
  output logic     gate_q
);
  logic req_d, gate_d;
  logic req_en, gate_en;

  always_comb begin
    req_d  = req_q;
    gate_d = gate_q;
    unique case (wr_kind)
      WK_BASE: begin
        req_d  = wr_srst;
        gate_d = wr_gate;
      end
      WK_SET: begin
        if (wr_srst) req_d  = 1'b1;
        if (wr_gate) gate_d = 1'b1;
      end
      WK_CLR: begin
        if (wr_srst) req_d  = 1'b0;
        if (wr_gate) gate_d = 1'b0;
      end
      default: ;
    endcase
    // enable-only build: soft reset may fall but never rise
    if (!ALLOW_RESET && req_d && !req_q) req_d = 1'b0;
    // settled soft reset holds the gate on
    if (settled) gate_d = 1'b1;
    req_en  = (req_d != req_q);
    gate_en = (gate_d != gate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b1;
      gate_q <= 1'b1;
    end else begin
      if (req_en)  req_q  <= req_d;
      if (gate_en) gate_q <= gate_d;
    end
  end
endmodule

// File: rtl/modrst_ctrl.sv
module modrst_ctrl
  import modrst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SETTLE      = 3,
  parameter bit          ALLOW_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mod_rst,
  output logic              mod_clk_en
);
  localparam int unsigned SRST_POS = DATA_W - 1;
  localparam int unsigned GATE_POS = DATA_W - 2;

  logic     rst_sync_n;
  wr_kind_e wr_kind;
  logic     rd_hit;
  logic     req_q, gate_q, settled;
  logic     unused_wdata;

  assign unused_wdata = ^bus_wdata[GATE_POS-1:0];

  modrst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  modrst_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_kind  (wr_kind),
    .rd_hit   (rd_hit)
  );

  modrst_bits #(.ALLOW_RESET(ALLOW_RESET)) u_bits (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_kind (wr_kind),
    .wr_srst (bus_wdata[SRST_POS]),
    .wr_gate (bus_wdata[GATE_POS]),
    .settled (settled),
    .req_q   (req_q),
    .gate_q  (gate_q)
  );

  modrst_settle #(.DEPTH(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (req_q),
    .q     (settled)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      bus_rdata[SRST_POS] = settled;
      bus_rdata[GATE_POS] = gate_q;
    end
  end

  assign mod_rst    = settled;
  assign mod_clk_en = ~gate_q;
endmodule

// File: rtl/modrst_ctrl_chk.sv
module modrst_ctrl_chk #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter bit          ALLOW_RESET = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mod_rst,
  input logic              mod_clk_en
);
  localparam logic [ADDR_W-1:0] C_BASE = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] C_SET  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] C_CLR  = ADDR_W'(4'h8);

  logic mapped;
  assign mapped = (bus_addr == C_BASE) || (bus_addr == C_SET) || (bus_addr == C_CLR);

  p_gate_follows_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mod_rst) |-> !mod_clk_en);

  p_set_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_SET && bus_wdata[DATA_W-2]) |=> !mod_clk_en);

  p_clr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == C_CLR && bus_wdata[DATA_W-2] && !mod_rst) |=> mod_clk_en);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));

  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-3:0] == '0);

  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mapped |-> (bus_rdata[DATA_W-1] == mod_rst && bus_rdata[DATA_W-2] == !mod_clk_en));

  if (ALLOW_RESET == 1'b0) begin : g_enable_only
    p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(mod_rst));
  end
endmodule

bind modrst_ctrl modrst_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALLOW_RESET(ALLOW_RESET)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .mod_rst    (mod_rst),
  .mod_clk_en (mod_clk_en)
);

// File: tb/modrst_ctrl_bench.sv
module modrst_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_full, rd_eo;
  logic        rst_full, rst_eo, en_full, en_eo;

  int n_vec;
  int n_bad;
  bit live;

  modrst_ctrl #(.ALLOW_RESET(1'b1)) u_modrst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_full), .mod_rst(rst_full), .mod_clk_en(en_full)
  );

  modrst_ctrl #(.ALLOW_RESET(1'b0)) u_eo (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_eo), .mod_rst(rst_eo), .mod_clk_en(en_eo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model: index 0 full build, index 1 enable-only
  bit m_req  [2];
  bit m_gate [2];
  bit m_hist [2][3];   // m_hist[i][0] is the settled value

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_req[i] = 1'b1; m_gate[i] = 1'b1;
        for (int k = 0; k < 3; k++) m_hist[i][k] = 1'b1;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit nreq, ngate;
        nreq = m_req[i]; ngate = m_gate[i];
        if (bus_wr) begin
          if (bus_addr == 4'h0) begin
            nreq = bus_wdata[31]; ngate = bus_wdata[30];
          end else if (bus_addr == 4'h4) begin
            if (bus_wdata[31]) nreq = 1'b1;
            if (bus_wdata[30]) ngate = 1'b1;
          end else if (bus_addr == 4'h8) begin
            if (bus_wdata[31]) nreq = 1'b0;
            if (bus_wdata[30]) ngate = 1'b0;
          end
        end
        if (i == 1 && nreq && !m_req[i]) nreq = 1'b0;
        if (m_hist[i][0]) ngate = 1'b1;
        m_hist[i][0] = m_hist[i][1];
        m_hist[i][1] = m_hist[i][2];
        m_hist[i][2] = m_req[i];
        m_req[i] = nreq; m_gate[i] = ngate;
      end
    end
  end

  function automatic logic [31:0] m_rdata(int i, logic [3:0] a);
    if (a == 4'h0 || a == 4'h4 || a == 4'h8) return {m_hist[i][0], m_gate[i], 30'd0};
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // cycle compare, half a period after each edge (R4 R5 R6 R9 R10)
  always @(negedge clk) begin
    if (live) begin
      chk("R4/R6 full rdata", rd_full, m_rdata(0, bus_addr));
      chk("R6 full mod_rst", 32'(rst_full), 32'(m_hist[0][0]));
      chk("R6 full clk_en", 32'(en_full), 32'(!m_gate[0]));
      chk("R7 eo rdata", rd_eo, m_rdata(1, bus_addr));
      chk("R7 eo mod_rst", 32'(rst_eo), 32'(m_hist[1][0]));
      chk("R7 eo clk_en", 32'(en_eo), 32'(!m_gate[1]));
    end
  end

  task automatic drive(logic wr, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    drive(1'b1, a, d);
    drive(1'b0, 4'h0, 32'd0);
  endtask

  task automatic idle(int n);
    repeat (n) drive(1'b0, 4'h0, 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int pulses;
    n_vec = 0; n_bad = 0; live = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    live = 1'b1;

    // R1 power-on state
    chk("R1 rdata", rd_full, 32'hC000_0000);
    chk("R1 mod_rst", 32'(rst_full), 32'd1);
    chk("R1 clk_en", 32'(en_full), 32'd0);
    chk("R1 eo rdata", rd_eo, 32'hC000_0000);

    // R4: clear soft reset, visible exactly three edges later
    do_write(4'h8, 32'h8000_0000);
    chk("R4 old after edge", 32'(rst_full), 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R4 old two later", rd_full, 32'hC000_0000);
    @(negedge clk);
    chk("R4 new three later", rd_full, 32'h4000_0000);
    chk("R2 gate untouched", 32'(en_full), 32'd0);
    do_write(4'h8, 32'h4000_0000);
    chk("R2 clear gate", 32'(en_full), 32'd1);
    chk("R7 eo enabled", rd_eo, 32'h0000_0000);

    // R9 same value at every mapped offset
    drive(1'b0, 4'h4, 32'd0);
    chk("R9 set offset read", rd_full, 32'h0000_0000);
    do_write(4'h4, 32'h4000_0000);
    drive(1'b0, 4'h0, 32'd0);
    chk("R9 base read", rd_full, 32'h4000_0000);
    drive(1'b0, 4'h4, 32'd0);
    chk("R9 set read", rd_full, 32'h4000_0000);
    drive(1'b0, 4'h8, 32'd0);
    chk("R9 clr read", rd_full, 32'h4000_0000);
    idle(4);
    chk("R2 set gate only", 32'(rst_full), 32'd0);

    // R3 base overwrite with junk low bits
    do_write(4'h0, 32'h0000_1234);
    chk("R3 base clears gate", rd_full, 32'h0000_0000);
    do_write(4'h0, 32'h4000_FFFF);
    chk("R3 base sets gate", rd_full, 32'h4000_0000);
    do_write(4'h0, 32'h0000_0000);

    // R5 full reset sequence
    do_write(4'h4, 32'h8000_0000);
    idle(2);
    chk("R5 gate before settle", 32'(en_full), 32'd1);
    idle(2);
    chk("R5 gate set by hw", 32'(en_full), 32'd0);
    chk("R7 eo ignores set", 32'(rst_eo), 32'd0);
    do_write(4'h8, 32'h4000_0000);
    chk("R5 gate clear ignored", 32'(en_full), 32'd0);
    do_write(4'h8, 32'h8000_0000);
    idle(4);
    chk("R5 gate sticky", rd_full, 32'h4000_0000);
    do_write(4'h8, 32'h4000_0000);
    chk("R5 gate cleared", 32'(en_full), 32'd1);

    // R10 back-to-back set then clear
    drive(1'b1, 4'h4, 32'h8000_0000);
    drive(1'b1, 4'h8, 32'h8000_0000);
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 4'h0, 32'd0);
      if (rst_full) pulses++;
    end
    chk("R10 pulse width", 32'(pulses), 32'd1);
    chk("R10 gate left set", 32'(en_full), 32'd0);
    do_write(4'h8, 32'h4000_0000);

    // R8 unmapped offset
    do_write(4'hC, 32'hFFFF_FFFF);
    idle(4);
    chk("R8 no effect", rd_full, 32'h0000_0000);
    drive(1'b0, 4'hC, 32'd0);
    chk("R8 read zero", rd_full, 32'h0000_0000);

    // R7 base write tries reset on enable-only build
    do_write(4'h0, 32'hC000_0000);
    idle(4);
    chk("R7 full reset", rd_full, 32'hC000_0000);
    chk("R7 eo srst held 0", rd_eo, 32'h4000_0000);
    do_write(4'h8, 32'hC000_0000);
    idle(5);
    do_write(4'h8, 32'h4000_0000);
    chk("R7 eo re-enabled", 32'(en_eo), 32'd1);
    idle(2);
    finish_run();
  end
endmodule